// File: doc/BRIEF.md
# Unrolled AES-128 Block Encryptor

This block encrypts 128-bit blocks with AES-128 in a fully unrolled datapath. A new plaintext block may be presented on every clock. Each of the ten rounds sits in its own registered stage, so one ciphertext block leaves the pipeline per clock after a fixed delay of ten cycles. The eleven round keys are expanded elsewhere and arrive on one flat bus. The datapath has no branches and no data-dependent memory accesses. Every byte substitution is computed in logic, so the timing is the same for any data and any key.

The whitening step XORs the plaintext with round key 0 and feeds the first stage directly. Stages one to nine each perform a full round: byte substitution, row shifting, column mixing and key addition. Stage ten skips column mixing. A valid bit travels in a shift register beside the data.

The key bus is static. It must be held steady while any block that uses it is still inside the pipeline.

Top module: `aes128_pipe`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly ten clock cycles, for any pattern of valid and idle cycles.
- R2: While `rst_n` is low, every in-flight valid bit is cleared and `in_valid` is ignored. After release, `out_valid` stays low until blocks presented after reset have had ten cycles to pass through.
- R3: Round key i occupies `round_keys[128*i +: 128]` for i = 0..10. Key 0 is XORed into the plaintext before the first round. Round i adds key i.
- R4: State byte n (n = 0..15) is bits `[127-8n -: 8]` of a block, and bytes fill the state column by column. With key 000102..0f (expanded) and plaintext 00112233445566778899aabbccddeeff, the ciphertext is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: Blocks presented on consecutive cycles produce correct ciphertexts on consecutive cycles, in order, with no stall.
- R6: Rounds one to nine mix columns. Round ten does not, so its output is substitution, row shift and key addition only.
- R7: Whenever `out_valid` is high, `ciphertext` has no unknown bits.
- R8: Latency and result are independent of data and key values. Blocks under arbitrary keys and plaintexts emerge exactly ten cycles after entry with the standard AES-128 result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the valid chain |
| in_valid | input | 1 | Plaintext present this cycle |
| plaintext | input | 128 | Input block, byte 0 in the top bits |
| round_keys | input | 1408 | Eleven round keys, key i at bits 128*i upward |
| out_valid | output | 1 | Ciphertext present this cycle |
| ciphertext | output | 128 | Output block, byte 0 in the top bits |

## Verification
The published example vector pins down the byte order, the key-bus layout and the whitening step. A swapped key slot or a reversed byte order would produce a completely different ciphertext. Long back-to-back streams and gapped streams under random keys are compared against an independently built reference. These catch a stage that mixes columns in the last round, a wrong row-shift direction, or a valid chain that is one stage too short or too long, since such an error shows up as a wrong value or a block arriving one cycle off. A reset applied while blocks are in flight and `in_valid` is held high exposes a valid chain that survives reset and emits stale blocks.

// File: rtl/aes128_pipe.sv
module aes128_pipe #(
  parameter int NR = 10,
  parameter int BW = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [BW-1:0]      plaintext,
  input  logic [(NR+1)*BW-1:0] round_keys,
  output logic               out_valid,
  output logic [BW-1:0]      ciphertext
);
  localparam int NB = BW / 8;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa;
    p = 8'h00;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xt(aa);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] sq, inv;
    sq = x;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gmul(sq, sq);
      inv = gmul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [BW-1:0] round_fn(input logic [BW-1:0] s,
                                              input logic [BW-1:0] k,
                                              input logic last);
    logic [7:0] b [NB];
    logic [7:0] t [NB];
    logic [7:0] a0, a1, a2, a3;
    logic [BW-1:0] o;
    for (int n = 0; n < NB; n++) b[n] = sbox(s[BW-1-8*n -: 8]);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        t[4*c+r] = b[4*((c+r)%4)+r];
    if (!last) begin
      for (int c = 0; c < 4; c++) begin
        a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
        t[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
        t[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
        t[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
        t[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
      end
    end
    for (int n = 0; n < NB; n++) o[BW-1-8*n -: 8] = t[n];
    return o ^ k;
  endfunction

  logic [BW-1:0] st [NR+1];
  logic [NR:1]   vld;

  assign st[0] = plaintext ^ round_keys[BW-1:0];

  for (genvar i = 1; i <= NR; i++) begin : g_round
    always_ff @(posedge clk)
      st[i] <= round_fn(st[i-1], round_keys[BW*i +: BW], i == NR);
  end

  always_ff @(posedge clk)
    if (!rst_n) vld <= '0;
    else        vld <= {vld[NR-1:1], in_valid};

  assign out_valid  = vld[NR];
  assign ciphertext = st[NR];
endmodule

module aes128_pipe_chk #(
  parameter int NR = 10,
  parameter int BW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [BW-1:0] ciphertext
);
  localparam int CW = $clog2(NR + 1);
  logic [NR-1:0] shadow;
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk)
    if (!rst_n) begin
      shadow    <= '0;
      since_rst <= '0;
    end else begin
      shadow <= {shadow[NR-2:0], in_valid};
      if (since_rst != CW'(NR)) since_rst <= since_rst + 1'b1;
    end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == shadow[NR-1]);

  assert_reset_clear_R2: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_reset_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != CW'(NR)) |-> !out_valid);

  assert_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(ciphertext));
endmodule

bind aes128_pipe aes128_pipe_chk #(.NR(NR), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .ciphertext(ciphertext)
);

// File: tb/test_aes128_pipe.sv
`timescale 1ns/1ps
module test_aes128_pipe;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [127:0]  plaintext = '0;
  logic [1407:0] round_keys = '0;
  logic          out_valid;
  logic [127:0]  ciphertext;

  aes128_pipe i_aes128_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .plaintext(plaintext),
    .round_keys(round_keys), .out_valid(out_valid), .ciphertext(ciphertext)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [7:0] sb [256];
  logic [127:0] exp_q [$];
  int           due_q [$];
  string        tag_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  initial begin
    logic [7:0] p, q;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ xt(p);
      q = q ^ (q << 1); q = q ^ (q << 2); q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]}
                ^ {q[3:0], q[7:4]} ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  end

  function automatic logic [1407:0] expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] tmp;
    logic [7:0]  rc;
    logic [1407:0] rk;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {sb[tmp[23:16]] ^ rc, sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int r = 0; r < 11; r++)
      rk[128*r +: 128] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    return rk;
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [1407:0] rk);
    logic [7:0] s [4][4];
    logic [7:0] u [4][4];
    logic [7:0] a, b, c, d;
    for (int col = 0; col < 4; col++)
      for (int row = 0; row < 4; row++)
        s[row][col] = pt[127-8*(4*col+row) -: 8] ^ rk[127-8*(4*col+row) -: 8];
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int row = 0; row < 4; row++)
        for (int col = 0; col < 4; col++)
          u[row][col] = sb[s[row][(col+row)%4]];
      if (rnd != 10)
        for (int col = 0; col < 4; col++) begin
          a = u[0][col]; b = u[1][col]; c = u[2][col]; d = u[3][col];
          u[0][col] = xt(a ^ b) ^ b ^ c ^ d;
          u[1][col] = xt(b ^ c) ^ c ^ d ^ a;
          u[2][col] = xt(c ^ d) ^ d ^ a ^ b;
          u[3][col] = xt(d ^ a) ^ a ^ b ^ c;
        end
      for (int col = 0; col < 4; col++)
        for (int row = 0; row < 4; row++)
          s[row][col] = u[row][col] ^ rk[128*rnd + 127 - 8*(4*col+row) -: 8];
    end
    for (int col = 0; col < 4; col++)
      for (int row = 0; row < 4; row++)
        ref_enc[127-8*(4*col+row) -: 8] = s[row][col];
  endfunction

  task automatic send(input logic [127:0] pt, input logic [127:0] exp, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    plaintext = pt;
    exp_q.push_back(exp);
    due_q.push_back(cyc + 10);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      plaintext = {4{$urandom}};
    end
  endtask

  // Scoreboard monitor: R1 timing, R4/R5/R6/R8 values, R2 no stray outputs
  always @(negedge clk) begin
    if (rst_n) begin
      while (due_q.size() > 0 && due_q[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s/R1: out_valid=0 expected=1 at cycle %0d", tag_q[0], due_q[0]);
        void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
      end
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2/R1: out_valid=1 expected=0 at cycle %0d", cyc);
        end else begin
          if (due_q[0] != cyc || ciphertext !== exp_q[0]) begin
            errors++;
            $display("FAIL %s: cycle=%0d data=%h expected cycle=%0d data=%h",
                     tag_q[0], cyc, ciphertext, due_q[0], exp_q[0]);
          end
          void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: done=0 expected=1");
    finish_run();
  end

  initial begin
    logic [1407:0] rk;
    logic [127:0] pt;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R2: reset out_valid=%b expected=0", out_valid);
    end
    rst_n = 1'b1;

    // R3 R4: published example vector
    round_keys = expand(128'h000102030405060708090a0b0c0d0e0f);
    send(128'h00112233445566778899aabbccddeeff,
         128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4");
    idle(14);

    // R5 R6: back-to-back stream under the same key
    rk = expand(128'h000102030405060708090a0b0c0d0e0f);
    for (int i = 0; i < 16; i++) begin
      pt = {4{$urandom}} ^ {120'h0, 8'(i)};
      send(pt, ref_enc(pt, rk), "R5");
    end
    idle(14);

    // R8 R3: arbitrary round keys, gapped traffic
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < 11; j++) rk[128*j +: 128] = {$urandom, $urandom, $urandom, $urandom};
      round_keys = rk;
      for (int i = 0; i < 8; i++) begin
        pt = {$urandom, $urandom, $urandom, $urandom};
        send(pt, ref_enc(pt, rk), "R8");
        if (i % 3 == k) idle(i % 2 + 1);
      end
      send(128'h0, ref_enc(128'h0, rk), "R6");
      send({128{1'b1}}, ref_enc({128{1'b1}}, rk), "R6");
      idle(14);
    end

    // R2: reset while blocks are in flight and in_valid is held high
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_valid = 1'b1; plaintext = {4{$urandom}};
    end
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete(); due_q.delete(); tag_q.delete();
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R2: in-reset out_valid=%b expected=0", out_valid);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(16);
    checks++;
    if (exp_q.size() != 0) begin
      errors++; $display("FAIL R1: pending=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule